// File: doc/BRIEF.md
# Two-wire serial register bank slave

This block is a slave on a two-wire open-drain serial bus (I2C). A bus master uses it to reach fourteen 8-bit control registers at locations 00h to 0Dh. The bus lines are brought into the system clock domain through synchronizers. The block finds START, repeated START and STOP conditions, compares the 7-bit device address, and then runs either a write transfer or a read transfer. The current value of every register appears on a flat parallel output bus, so the logic around the block can use the settings directly.

A single location pointer serves both directions. In a write transfer, the first byte after the address loads the pointer, and each later byte is stored at the pointer. A read transfer starts at the pointer. A random read is a write transfer that carries only the location byte, followed by a repeated START and a read. After every data byte, in either direction, the pointer moves to the next location. After 0Dh it returns to 00h. The block acknowledges by pulling SDA low and releases SDA whenever it is not actively driving a zero. Clock stretching, 10-bit addressing and general call are not supported.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After the asynchronous active-low reset, every register reads 00h, the pointer is 00h and SDA is released (sda_oe = 0).
- R2: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR, and bit 0 selects the direction (1 = read, 0 = write). On any other address it never drives SDA, and the bytes that follow change no register until the next START or STOP.
- R3: In a write transfer, the first byte after the address loads the pointer. Each later byte is stored at the pointer location. Every one of these bytes is acknowledged, and the pointer then advances by one.
- R4: When the pointer advances from 0Dh it wraps to 00h, in both reads and writes. Further write bytes then overwrite the registers from 00h upward.
- R5: A read transfer returns the register at the pointer and then advances the pointer. Any read that follows an access to location n returns location n+1, whether that access was a read or a write.
- R6: A random read, made of a write transfer with only a location byte, then a repeated START and a read address, returns data starting at that location.
- R7: When the master acknowledges a read byte, the next location follows. After a master NACK and a STOP, the block no longer drives SDA.
- R8: A location byte above 0Dh is folded into range modulo 14. For example, 10h selects 02h and FFh selects 03h.
- R9: SDA is changed only while SCL is low. The block releases SDA after each acknowledge or data bit it drives, and it never drives SDA during the master's acknowledge bit.
- R10: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point abandons the transfer in progress, and a partly received byte is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NUM_REGS*8 | All registers, register k at bits [8k+7:8k] |

## Verification
Two things can happen on the same clock edge: the store of a write byte into register 0Dh, and the wrap of the pointer to 00h. The bench provokes this by writing three bytes starting at location 0Ch. It then checks that 0Dh holds the second byte and that 00h holds the third. A current-address read afterwards must return location 01h. Reads that run across the same boundary exercise the wrap on the read path, in the cycle where the next byte is loaded.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } bus_state_e;

  // fold an incoming location byte into the implemented range
  function automatic int unsigned fold_loc(input int unsigned loc, input int unsigned nregs);
    return loc % nregs;
  endfunction

  // next pointer value, wrapping after the last register
  function automatic int unsigned step_loc(input int unsigned loc, input int unsigned nregs);
    return (loc + 1 >= nregs) ? 0 : loc + 1;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 14,
  parameter int PTR_W    = 5,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [PTR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  logic [DATA_W-1:0] store [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store[g] <= '0;
      end else if (wr_en && (wr_addr == PTR_W'(g))) begin
        store[g] <= wr_data;
      end
    end
    assign regs_flat[g*DATA_W +: DATA_W] = store[g];
  end

  // locations without a register read as zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == PTR_W'(i)) rd_data = store[i];
    end
  end

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         NUM_REGS = 14,
  parameter int         PTR_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] ptr_o,
  output logic             ignoring
);

  bus_state_e       state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] ptr;
  logic             rw_q;
  logic             mack_q;
  logic             oe_q;
  logic             byte_done;
  logic             bus_evt;
  logic [PTR_W-1:0] ptr_next;
  logic [PTR_W-1:0] ptr_loaded;

  assign bus_evt    = start_evt | stop_evt;
  assign byte_done  = scl_fall && (bitcnt == 4'd8);
  assign ptr_next   = PTR_W'(step_loc(32'(ptr), NUM_REGS));
  assign ptr_loaded = PTR_W'(fold_loc(32'(shreg), NUM_REGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                rw_q  <= shreg[0];
                oe_q  <= 1'b1;
                state <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (state == ST_SUB) begin
              ptr   <= ptr_loaded;
              oe_q  <= 1'b1;
              state <= ST_SUB_ACK;
            end else begin
              ptr   <= ptr_next;
              oe_q  <= 1'b1;
              state <= ST_WACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              shreg  <= rd_data;
              oe_q   <= ~rd_data[7];
              bitcnt <= 4'd1;
              ptr    <= ptr_next;
              state  <= ST_RDATA;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              oe_q  <= 1'b0;
              state <= ST_RACK;
            end else begin
              oe_q   <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              shreg  <= rd_data;
              oe_q   <= ~rd_data[7];
              bitcnt <= 4'd1;
              ptr    <= ptr_next;
              state  <= ST_RDATA;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en    = (state == ST_WDATA) && byte_done && !bus_evt;
  assign wr_addr  = ptr;
  assign wr_data  = shreg;
  assign ptr_o    = ptr;
  assign sda_oe   = oe_q;
  assign ignoring = (state == ST_IGNORE);

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         NUM_REGS    = 14,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_evt;
  logic             stop_evt;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic [7:0]       wr_data;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rd_data;
  logic             ignoring;
  logic             scl_low;

  assign scl_low = ~scl_s;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_proto_fsm #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ptr_o     (ptr),
    .ignoring  (ignoring)
  );

  i2c_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W),
    .DATA_W   (8)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (ptr),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );

endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk #(
  parameter int NUM_REGS = 14,
  parameter int PTR_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_low,
  input logic             sda_oe,
  input logic [PTR_W-1:0] ptr,
  input logic             wr_en,
  input logic             ignoring,
  input logic             start_evt
);

  // R9: the data line only moves while the synchronized clock is low
  p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> scl_low);

  // R8: the pointer never leaves the implemented range
  p_ptr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PTR_W'(NUM_REGS));

  // R4: a write at the last register is followed by pointer 00h
  p_write_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == PTR_W'(NUM_REGS - 1)) |=> (ptr == '0));

  // R2: a non-addressed slave stays off the bus
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  // R10: a START leaves the line released and the slave listening
  p_start_rearms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && !ignoring));

endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(
  .NUM_REGS (NUM_REGS),
  .PTR_W    (PTR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_low   (scl_low),
  .sda_oe    (sda_oe),
  .ptr       (ptr),
  .wr_en     (wr_en),
  .ignoring  (ignoring),
  .start_evt (start_evt)
);

// File: tb/i2c_regbank_slave_test.sv
`timescale 1ns/1ps
module i2c_regbank_slave_test;

  localparam logic [6:0] DEV = 7'h3A;
  localparam int NR = 14;
  localparam int Q  = 12;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ref_regs [NR];
  int ref_ptr = 0;
  exp_t exp_q [$];
  logic [7:0] obs_q [$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_regbank_slave #(.DEV_ADDR(DEV), .NUM_REGS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each observed read byte with the next expected one
  initial begin
    forever begin
      @(negedge clk);
      if (obs_q.size() > 0 && exp_q.size() > 0) begin
        exp_t e;
        logic [7:0] o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        check(o == e.v, e.tag, o, e.v);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  task automatic bit_slot(input logic drv, output logic seen);
    sda_m = drv; w(Q);
    scl = 1'b1; w(Q);
    seen = sda_line; w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q);
    scl = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q);
    scl = 1'b1; w(Q);
    sda_m = 1'b1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], s);
    bit_slot(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_slot(1'b1, s);
      b[i] = s;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; w(Q);
    scl = 1'b1; w(Q);
    check(sda_oe == 1'b0, "R9 master ack slot free", sda_oe, 0);
    w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic addr_phase(input logic rw, input string tag);
    bit a;
    send_byte({DEV, rw}, a);
    check(a, tag, a, 1);
  endtask

  task automatic read_run(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.v = ref_regs[ref_ptr];
      e.tag = tag;
      exp_q.push_back(e);
      ref_ptr = (ref_ptr + 1) % NR;
      recv_byte(i < n - 1, b);
      obs_q.push_back(b);
    end
    bus_stop();
    w(4);
    check(sda_oe == 1'b0, "R7 released after nack and stop", sda_oe, 0);
  endtask

  task automatic do_write(input int loc, input int n, input logic [7:0] seed, input string tag);
    bit a;
    bus_start();
    addr_phase(1'b0, "R2 write address ack");
    send_byte(8'(loc), a);
    check(a, "R3 location byte ack", a, 1);
    ref_ptr = loc % NR;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = seed + 8'(i * 8'h13);
      send_byte(v, a);
      check(a, "R3 data byte ack", a, 1);
      ref_regs[ref_ptr] = v;
      ref_ptr = (ref_ptr + 1) % NR;
    end
    bus_stop();
    w(4);
    for (int k = 0; k < NR; k++)
      check(regs_o[k*8 +: 8] == ref_regs[k], tag, regs_o[k*8 +: 8], ref_regs[k]);
  endtask

  task automatic do_rand_read(input int loc, input int n, input string tag);
    bit a;
    bus_start();
    addr_phase(1'b0, "R6 dummy write address ack");
    send_byte(8'(loc), a);
    check(a, "R6 location ack", a, 1);
    ref_ptr = loc % NR;
    bus_start();
    addr_phase(1'b1, "R6 read address ack");
    read_run(n, tag);
  endtask

  task automatic do_cur_read(input int n, input string tag);
    bus_start();
    addr_phase(1'b1, "R5 current read address ack");
    read_run(n, tag);
  endtask

  initial begin
    for (int k = 0; k < NR; k++) ref_regs[k] = 8'h00;
    w(5);
    check(regs_o == '0, "R1 registers cleared", 0, 0);
    check(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    rst_n = 1'b1;
    w(5);

    // R1/R5: first read after reset comes from location 00h
    do_cur_read(1, "R1 read after reset");

    // R3: plain burst write
    do_write(0, 5, 8'h10, "R3 burst write");

    // R6/R7: random read with a continued burst
    do_rand_read(1, 2, "R6 random read");

    // R5: pointer follows the last read
    do_cur_read(1, "R5 current read after read");

    // R4: write burst across 0Dh with same-edge store and wrap
    do_write(12, 3, 8'hA0, "R4 write across wrap");
    do_cur_read(1, "R5 current read after write");

    // R4/R7: read burst across the boundary
    do_rand_read(12, 4, "R4 read across wrap");

    // R8: out-of-range locations fold modulo 14
    do_write(8'h10, 1, 8'h5C, "R8 location 10h folds to 02h");
    do_write(8'hFF, 1, 8'h6D, "R8 location FFh folds to 03h");
    do_cur_read(1, "R8 pointer after folded write");

    // R2: foreign address is ignored
    begin
      bit a;
      bus_start();
      send_byte({7'h21, 1'b0}, a);
      check(!a, "R2 foreign address not acked", a, 0);
      send_byte(8'h00, a);
      check(!a, "R2 foreign location not acked", a, 0);
      send_byte(8'hEE, a);
      check(!a, "R2 foreign data not acked", a, 0);
      bus_stop();
      w(4);
      check(regs_o[7:0] == ref_regs[0], "R2 register 00h untouched", regs_o[7:0], ref_regs[0]);
    end

    // R10: repeated START in the middle of a data byte
    begin
      bit a;
      logic s;
      bus_start();
      addr_phase(1'b0, "R10 address ack");
      send_byte(8'h05, a);
      check(a, "R10 location ack", a, 1);
      ref_ptr = 5;
      for (int i = 0; i < 4; i++) bit_slot(1'b0, s);
      bus_start();
      bus_stop();
      w(4);
      check(regs_o[5*8 +: 8] == ref_regs[5], "R10 partial byte dropped",
            regs_o[5*8 +: 8], ref_regs[5]);
    end
    do_cur_read(1, "R10 pointer kept after abort");

    w(20);
    check(exp_q.size() == 0, "R5 all reads compared", exp_q.size(), 0);
    done = 1'b1;
    summary();
  end

endmodule